// File: doc/BRIEF.md
# SPI NOR Flash Slave Emulator

This block is a small serial NOR flash that answers on a SPI mode-0 bus, meant for simulation benches and FPGA prototypes that need a flash to boot from or log into. It oversamples the bus pins (serial clock, active-low select, data in) on its own system clock. A byte engine decodes the first byte of each select window as an opcode. It then collects a 24-bit address, most significant byte first, and moves into an identification, status, array-read, page-program or erase phase.

The array lives inside the block and its size is a parameter (4 KiB by default). After reset the whole array is swept to 0xFF before the first command is served. Programming can only clear bits. Erase commands fill an aligned region with 0xFF, one byte per system clock, after the select is released. A write-enable latch guards both operations. A busy flag covers the erase sweep and a fixed program settle time, and during that time only status reads are answered.

The serial clock half-period must span at least six system clocks.

Top module: `sfe_flash_emu`

## Requirements
- R1: While select is high the data-out pin is 1; while the opcode, the three address bytes and the fast-read dummy byte shift in, every output byte is 0xFF.
- R2: Opcode 0x9F returns the three DEVICE_ID bytes, high byte first (EF 40 18 by default), then 0x00 for every later byte.
- R3: Opcode 0x03 plus a 3-byte address returns array bytes starting at that address, incrementing by one per byte and wrapping from the last array location to location 0.
- R4: Opcode 0x0B works like 0x03 but inserts one dummy byte (output 0xFF) between the address and the first data byte.
- R5: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it; the low status byte has busy at bit 0 and the latch at bit 1, other bits 0.
- R6: Opcode 0x05 repeats the low status byte for as long as clocks continue; opcode 0x35 repeats the upper status byte, which is 0x00.
- R7: Opcode 0x02 plus an address programs the following data bytes only when the latch is set; each stored byte becomes old AND new, the address wraps inside its 256-byte page, and the latch is clear afterwards.
- R8: Opcodes 0x20 (4 KiB), 0xD8 (64 KiB) and 0xC7 (whole array) take an address and fill the aligned region with 0xFF; without the latch they do nothing, and with the latch but a misaligned address they do nothing except clear the latch.
- R9: From select release after an accepted erase or program until its sweep or settle time ends, busy reads 1 and every opcode other than 0x05 and 0x35 is ignored.
- R10: An unknown opcode makes the rest of the select window output 0xFF with no effect; lowering select always restarts opcode decoding.
- R11: After reset the whole array reads 0xFF, and busy reads 1 until that initial sweep ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | SPI serial clock, idle low |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data into the emulator |
| miso | output | 1 | Serial data out of the emulator |

## Verification
The bound checker watches every cycle that the output idles high outside a select window, that a new select window returns the decoder to opcode state, that no program write or latch set happens while busy, and that busy only rises once the latch has been consumed. The byte values themselves (identification order, AND-programming, page wrap, array wrap, the dummy byte, aligned versus misaligned erase and the post-reset fill) only show through the bench's scripted transactions, where each returned byte is compared against a queue of expected bytes.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
   localparam logic [7:0] OP_RDID   = 8'h9F;
   localparam logic [7:0] OP_READ   = 8'h03;
   localparam logic [7:0] OP_FREAD  = 8'h0B;
   localparam logic [7:0] OP_PROG   = 8'h02;
   localparam logic [7:0] OP_WREN   = 8'h06;
   localparam logic [7:0] OP_WRDI   = 8'h04;
   localparam logic [7:0] OP_RDSR   = 8'h05;
   localparam logic [7:0] OP_RDSR2  = 8'h35;
   localparam logic [7:0] OP_ER4K   = 8'h20;
   localparam logic [7:0] OP_ER64K  = 8'hD8;
   localparam logic [7:0] OP_ERALL  = 8'hC7;
   localparam logic [7:0] IDLE_BYTE = 8'hFF;

   typedef enum logic [3:0] {
      PH_OPC, PH_ADDR, PH_DUMMY, PH_ID, PH_STLO, PH_STHI, PH_READ, PH_PROG, PH_SKIP
   } phase_e;
endpackage

// File: rtl/sfe_serdes.sv
module sfe_serdes #(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sclk,
   input  logic       cs_n,
   input  logic       mosi,
   input  logic [7:0] tx_byte,
   output logic       cs_act,
   output logic       cs_start,
   output logic       cs_end,
   output logic       byte_valid,
   output logic [7:0] rx_byte,
   output logic       miso
);
   localparam logic [2:0] PIN_IDLE = 3'b010;   // {sclk, cs_n, mosi}

   logic [2:0] pins_raw, pins_s;
   logic       sclk_d, cs_d;
   logic [2:0] bit_cnt;
   logic [7:0] rx_sh, tx_sh;
   logic       rise, fall;

   assign pins_raw = {sclk, cs_n, mosi};

   for (genvar g = 0; g < 3; g++) begin : g_sync
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk) begin
         if (!rst_n) chain <= {SYNC_STAGES{PIN_IDLE[g]}};
         else        chain <= {chain[SYNC_STAGES-2:0], pins_raw[g]};
      end
      assign pins_s[g] = chain[SYNC_STAGES-1];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sclk_d <= 1'b0;
         cs_d   <= 1'b1;
      end else begin
         sclk_d <= pins_s[2];
         cs_d   <= pins_s[1];
      end
   end

   assign rise     = pins_s[2] & ~sclk_d;
   assign fall     = ~pins_s[2] & sclk_d;
   assign cs_act   = ~pins_s[1];
   assign cs_start = ~pins_s[1] & cs_d;
   assign cs_end   = pins_s[1] & ~cs_d;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bit_cnt    <= '0;
         rx_sh      <= '0;
         tx_sh      <= IDLE_BYTE_L;
         byte_valid <= 1'b0;
         rx_byte    <= '0;
      end else begin
         byte_valid <= 1'b0;
         if (cs_start || !cs_act) begin
            bit_cnt <= '0;
            tx_sh   <= IDLE_BYTE_L;
         end else begin
            if (rise) begin
               rx_sh   <= {rx_sh[6:0], pins_s[0]};
               bit_cnt <= bit_cnt + 3'd1;
               if (bit_cnt == 3'd7) begin
                  byte_valid <= 1'b1;
                  rx_byte    <= {rx_sh[6:0], pins_s[0]};
               end
            end
            if (fall) tx_sh <= (bit_cnt == 3'd0) ? tx_byte : {tx_sh[6:0], 1'b1};
         end
      end
   end

   localparam logic [7:0] IDLE_BYTE_L = 8'hFF;

   assign miso = cs_act ? tx_sh[7] : 1'b1;
endmodule

// File: rtl/sfe_engine.sv
module sfe_engine
   import sfe_pkg::*;
#(
   parameter int          MEM_BYTES = 4096,
   parameter logic [23:0] DEVICE_ID = 24'hEF4018,
   localparam int         AW        = $clog2(MEM_BYTES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs_start,
   input  logic          cs_end,
   input  logic          byte_valid,
   input  logic [7:0]    rx_byte,
   input  logic          busy,
   input  logic [7:0]    rd_data,
   output logic [7:0]    tx_byte,
   output logic [AW-1:0] rd_addr,
   output logic          wel,
   output logic          prog_we,
   output logic [7:0]    prog_data,
   output logic          erase_go,
   output logic [AW-1:0] erase_base,
   output logic [AW:0]   erase_len,
   output logic          prog_go,
   output phase_e        phase
);
   logic [7:0]  op;
   logic [15:0] addr_lo;
   logic [1:0]  acnt;
   logic [2:0]  idx;
   logic        pend_er, pend_pg;
   logic [23:0] addr_next, gran;
   logic        aligned;
   logic        is_erase;

   assign addr_next = {addr_lo, rx_byte};
   assign is_erase  = (op == OP_ER4K) || (op == OP_ER64K) || (op == OP_ERALL);

   always_comb begin
      case (op)
         OP_ER4K:  gran = 24'd4096;
         OP_ER64K: gran = 24'd65536;
         default:  gran = 24'(MEM_BYTES);
      endcase
   end
   assign aligned = (addr_next & (gran - 24'd1)) == 24'd0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase      <= PH_OPC;
         op         <= '0;
         addr_lo    <= '0;
         acnt       <= '0;
         idx        <= '0;
         wel        <= 1'b0;
         pend_er    <= 1'b0;
         pend_pg    <= 1'b0;
         erase_base <= '0;
         erase_len  <= '0;
      end else if (cs_start) begin
         phase   <= PH_OPC;
         addr_lo <= '0;
         acnt    <= '0;
         idx     <= '0;
      end else if (cs_end) begin
         pend_er <= 1'b0;
         pend_pg <= 1'b0;
      end else if (byte_valid) begin
         case (phase)
            PH_OPC: begin
               op <= rx_byte;
               if (busy && rx_byte != OP_RDSR && rx_byte != OP_RDSR2) phase <= PH_SKIP;
               else begin
                  case (rx_byte)
                     OP_RDID:  phase <= PH_ID;
                     OP_READ, OP_FREAD, OP_PROG,
                     OP_ER4K, OP_ER64K, OP_ERALL: phase <= PH_ADDR;
                     OP_WREN:  begin wel <= 1'b1; phase <= PH_SKIP; end
                     OP_WRDI:  begin wel <= 1'b0; phase <= PH_SKIP; end
                     OP_RDSR:  phase <= PH_STLO;
                     OP_RDSR2: phase <= PH_STHI;
                     default:  phase <= PH_SKIP;
                  endcase
               end
            end
            PH_ADDR: begin
               addr_lo <= addr_next[15:0];
               acnt    <= acnt + 2'd1;
               if (acnt == 2'd2) begin
                  if (op == OP_READ)       phase <= PH_READ;
                  else if (op == OP_FREAD) phase <= PH_DUMMY;
                  else if (op == OP_PROG && wel) begin
                     phase   <= PH_PROG;
                     pend_pg <= 1'b1;
                     wel     <= 1'b0;
                  end else begin
                     phase <= PH_SKIP;
                     if (is_erase && wel) begin
                        wel <= 1'b0;
                        if (aligned) begin
                           pend_er    <= 1'b1;
                           erase_base <= addr_next[AW-1:0];
                           erase_len  <= (gran > 24'(MEM_BYTES)) ? (AW+1)'(MEM_BYTES)
                                                                 : (AW+1)'(gran);
                        end
                     end
                  end
               end
            end
            PH_DUMMY: phase <= PH_READ;
            PH_READ:  addr_lo <= addr_lo + 16'd1;
            PH_PROG:  addr_lo[7:0] <= addr_lo[7:0] + 8'd1;
            PH_ID:    if (idx != 3'd4) idx <= idx + 3'd1;
            default:  ;
         endcase
      end
   end

   assign rd_addr   = addr_lo[AW-1:0];
   assign prog_we   = byte_valid && !cs_start && !cs_end && (phase == PH_PROG);
   assign prog_data = rx_byte & rd_data;
   assign erase_go  = cs_end && pend_er;
   assign prog_go   = cs_end && pend_pg;

   always_comb begin
      case (phase)
         PH_ID: begin
            case (idx)
               3'd0:    tx_byte = DEVICE_ID[23:16];
               3'd1:    tx_byte = DEVICE_ID[15:8];
               3'd2:    tx_byte = DEVICE_ID[7:0];
               default: tx_byte = 8'h00;
            endcase
         end
         PH_STLO: tx_byte = {6'b0, wel, busy};
         PH_STHI: tx_byte = 8'h00;
         PH_READ: tx_byte = rd_data;
         default: tx_byte = IDLE_BYTE;
      endcase
   end
endmodule

// File: rtl/sfe_store.sv
module sfe_store #(
   parameter int MEM_BYTES   = 4096,
   parameter int PROG_CYCLES = 1000,
   localparam int AW         = $clog2(MEM_BYTES),
   localparam int CW         = (PROG_CYCLES > 0) ? $clog2(PROG_CYCLES + 1) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] rd_addr,
   output logic [7:0]    rd_data,
   input  logic          prog_we,
   input  logic [7:0]    prog_data,
   input  logic          erase_go,
   input  logic [AW-1:0] erase_base,
   input  logic [AW:0]   erase_len,
   input  logic          prog_go,
   output logic          sweep_we,
   output logic          busy
);
   logic [7:0]    mem [MEM_BYTES];
   logic          sweeping, settling;
   logic [AW-1:0] ptr;
   logic [AW:0]   left;

   always_ff @(posedge clk) begin
      if (sweeping)     mem[ptr]     <= 8'hFF;
      else if (prog_we) mem[rd_addr] <= prog_data;
   end
   assign rd_data = mem[rd_addr];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sweeping <= 1'b1;
         ptr      <= '0;
         left     <= (AW+1)'(MEM_BYTES);
      end else if (erase_go) begin
         sweeping <= 1'b1;
         ptr      <= erase_base;
         left     <= erase_len;
      end else if (sweeping) begin
         ptr  <= ptr + 1'b1;
         left <= left - 1'b1;
         if (left == (AW+1)'(1)) sweeping <= 1'b0;
      end
   end

   if (PROG_CYCLES > 0) begin : g_settle
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
         if (!rst_n)       cnt <= '0;
         else if (prog_go) cnt <= CW'(PROG_CYCLES);
         else if (cnt != '0) cnt <= cnt - 1'b1;
      end
      assign settling = (cnt != '0);
   end else begin : g_instant
      assign settling = 1'b0;
   end

   assign sweep_we = sweeping;
   assign busy     = sweeping | settling;
endmodule

// File: rtl/sfe_flash_emu.sv
module sfe_flash_emu
   import sfe_pkg::*;
#(
   parameter int          MEM_BYTES   = 4096,
   parameter int          PROG_CYCLES = 1000,
   parameter int          SYNC_STAGES = 2,
   parameter logic [23:0] DEVICE_ID   = 24'hEF4018
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk,
   input  logic cs_n,
   input  logic mosi,
   output logic miso
);
   localparam int AW = $clog2(MEM_BYTES);

   if (MEM_BYTES < 256 || MEM_BYTES > 65536 || (MEM_BYTES & (MEM_BYTES - 1)) != 0) begin : g_bad_size
      $error("MEM_BYTES must be a power of two from 256 to 65536");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic          cs_act, cs_start, cs_end, byte_valid;
   logic [7:0]    rx_byte, tx_byte, rd_data, prog_data;
   logic [AW-1:0] rd_addr, erase_base;
   logic [AW:0]   erase_len;
   logic          wel, prog_we, erase_go, prog_go, sweep_we, busy;
   phase_e        phase;

   sfe_serdes #(.SYNC_STAGES(SYNC_STAGES)) u_serdes (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
      .tx_byte(tx_byte), .cs_act(cs_act), .cs_start(cs_start), .cs_end(cs_end),
      .byte_valid(byte_valid), .rx_byte(rx_byte), .miso(miso)
   );

   sfe_engine #(.MEM_BYTES(MEM_BYTES), .DEVICE_ID(DEVICE_ID)) u_engine (
      .clk(clk), .rst_n(rst_n), .cs_start(cs_start), .cs_end(cs_end),
      .byte_valid(byte_valid), .rx_byte(rx_byte), .busy(busy), .rd_data(rd_data),
      .tx_byte(tx_byte), .rd_addr(rd_addr), .wel(wel), .prog_we(prog_we),
      .prog_data(prog_data), .erase_go(erase_go), .erase_base(erase_base),
      .erase_len(erase_len), .prog_go(prog_go), .phase(phase)
   );

   sfe_store #(.MEM_BYTES(MEM_BYTES), .PROG_CYCLES(PROG_CYCLES)) u_store (
      .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
      .prog_we(prog_we), .prog_data(prog_data), .erase_go(erase_go),
      .erase_base(erase_base), .erase_len(erase_len), .prog_go(prog_go),
      .sweep_we(sweep_we), .busy(busy)
   );
endmodule

// File: rtl/sfe_flash_emu_chk.sv
module sfe_flash_emu_chk
   import sfe_pkg::*;
(
   input logic   clk,
   input logic   rst_n,
   input logic   cs_act,
   input logic   cs_start,
   input logic   miso,
   input logic   busy,
   input logic   wel,
   input logic   prog_we,
   input logic   byte_valid,
   input phase_e phase
);
   p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |-> miso);

   p_cs_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cs_start |=> phase == PH_OPC);

   p_no_prog_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      prog_we |-> !busy);

   p_no_wel_while_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wel) |-> !$past(busy));

   p_wel_by_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wel) |-> $past(byte_valid));

   p_wel_consumed_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !wel);
endmodule

bind sfe_flash_emu sfe_flash_emu_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .cs_start(cs_start), .miso(miso),
   .busy(busy), .wel(wel), .prog_we(prog_we), .byte_valid(byte_valid), .phase(phase)
);

// File: tb/sfe_flash_emu_test.sv
module sfe_flash_emu_test;
   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 6;
   localparam int SETTLE     = 1100;
   localparam int SWEEP_WAIT = 4400;

   logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
   logic miso;

   int total = 0, bad = 0;
   bit finished = 1'b0;

   logic [7:0] exp_q[$];
   string      tag_q[$];
   logic [7:0] mon_sh = 8'h00;
   int         mon_n = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sfe_flash_emu uut (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso)
   );

   task automatic check(input bit ok, input string tg, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: got %02h expected %02h", tg, act, exp);
      end
   endtask

   // monitor: assembles each byte the design returns and compares it with the queue
   always @(posedge sclk) begin
      if (!cs_n) begin
         mon_sh = {mon_sh[6:0], miso};
         mon_n++;
         if (mon_n == 8) begin
            mon_n = 0;
            if (exp_q.size() == 0) check(1'b0, "scoreboard-empty", mon_sh, 8'hxx);
            else begin
               logic [7:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check(mon_sh === e, t, mon_sh, e);
            end
         end
      end
   end

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic sel;
      cs_n = 1'b0;
      wait_clk(8);
   endtask

   task automatic desel;
      wait_clk(HALF);
      cs_n = 1'b1;
      wait_clk(8);
      check(miso === 1'b1, "R1 idle", {7'b0, miso}, 8'h01);
   endtask

   task automatic xb(input logic [7:0] mo, input logic [7:0] ex, input string tg);
      exp_q.push_back(ex);
      tag_q.push_back(tg);
      for (int i = 7; i >= 0; i--) begin
         mosi = mo[i];
         wait_clk(HALF);
         sclk = 1'b1;
         wait_clk(HALF);
         sclk = 1'b0;
      end
   endtask

   task automatic addr3(input logic [23:0] a);
      xb(a[23:16], 8'hFF, "R1 addr");
      xb(a[15:8],  8'hFF, "R1 addr");
      xb(a[7:0],   8'hFF, "R1 addr");
   endtask

   task automatic cmd1(input logic [7:0] op);
      sel; xb(op, 8'hFF, "R1 opcode"); desel;
   endtask

   task automatic rdsr(input logic [7:0] ex, input string tg);
      sel; xb(8'h05, 8'hFF, "R1 opcode"); xb(8'h00, ex, tg); desel;
   endtask

   task automatic rd1(input logic [23:0] a, input logic [7:0] ex, input string tg);
      sel; xb(8'h03, 8'hFF, "R1 opcode"); addr3(a); xb(8'h00, ex, tg); desel;
   endtask

   task automatic prog1(input logic [23:0] a, input logic [7:0] d);
      sel; xb(8'h02, 8'hFF, "R1 opcode"); addr3(a); xb(d, 8'hFF, "R1 prog data"); desel;
   endtask

   task automatic erase(input logic [7:0] op, input logic [23:0] a);
      sel; xb(op, 8'hFF, "R1 opcode"); addr3(a); desel;
   endtask

   initial begin
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(2);
      check(miso === 1'b1, "R1 reset idle", {7'b0, miso}, 8'h01);

      // R11: initial sweep keeps busy high, R6 repeats the status byte
      sel; xb(8'h05, 8'hFF, "R1 opcode"); xb(8'h00, 8'h01, "R11 busy after reset");
      xb(8'h00, 8'h01, "R6 status repeat"); desel;
      wait_clk(SWEEP_WAIT);
      rdsr(8'h00, "R11 sweep done");
      rd1(24'h000123, 8'hFF, "R11 array erased");

      // R2: identification
      sel; xb(8'h9F, 8'hFF, "R1 opcode");
      xb(8'h00, 8'hEF, "R2 id0"); xb(8'h00, 8'h40, "R2 id1"); xb(8'h00, 8'h18, "R2 id2");
      xb(8'h00, 8'h00, "R2 id tail"); xb(8'h00, 8'h00, "R2 id tail"); xb(8'h00, 8'h00, "R2 id tail");
      desel;

      // R3: plain read of erased array
      sel; xb(8'h03, 8'hFF, "R1 opcode"); addr3(24'h000010);
      xb(8'h00, 8'hFF, "R3 read"); xb(8'h00, 8'hFF, "R3 read"); desel;

      // R7: program without latch is ignored
      prog1(24'h000020, 8'hAA);
      rd1(24'h000020, 8'hFF, "R7 no latch no program");

      // R5 / R6: latch set and clear, upper status byte
      cmd1(8'h06);
      rdsr(8'h02, "R5 latch set");
      sel; xb(8'h35, 8'hFF, "R1 opcode"); xb(8'h00, 8'h00, "R6 upper status");
      xb(8'h00, 8'h00, "R6 upper repeat"); desel;
      cmd1(8'h04);
      rdsr(8'h00, "R5 latch cleared");

      // R7: page program with in-page wrap
      cmd1(8'h06);
      sel; xb(8'h02, 8'hFF, "R1 opcode"); addr3(24'h0000FE);
      xb(8'h11, 8'hFF, "R1 prog data"); xb(8'h22, 8'hFF, "R1 prog data");
      xb(8'h33, 8'hFF, "R1 prog data"); desel;
      wait_clk(SETTLE);
      rdsr(8'h00, "R7 latch cleared after program");
      sel; xb(8'h03, 8'hFF, "R1 opcode"); addr3(24'h0000FE);
      xb(8'h00, 8'h11, "R7 prog byte0"); xb(8'h00, 8'h22, "R7 prog byte1");
      xb(8'h00, 8'hFF, "R7 next page untouched"); desel;
      rd1(24'h000000, 8'h33, "R7 page wrap");

      // R7: program only clears bits
      cmd1(8'h06);
      prog1(24'h0000FE, 8'hF0);
      wait_clk(SETTLE);
      rd1(24'h0000FE, 8'h10, "R7 and-program");

      // R4: fast read with dummy byte
      sel; xb(8'h0B, 8'hFF, "R1 opcode"); addr3(24'h0000FE);
      xb(8'h00, 8'hFF, "R4 dummy"); xb(8'h00, 8'h10, "R4 data0"); xb(8'h00, 8'h22, "R4 data1");
      desel;

      // R3: wrap at the end of the array
      sel; xb(8'h03, 8'hFF, "R1 opcode"); addr3(24'h000FFF);
      xb(8'h00, 8'hFF, "R3 last byte"); xb(8'h00, 8'h33, "R3 wrap to 0"); desel;

      // R8: misaligned erase rejected, latch cleared
      cmd1(8'h06);
      erase(8'h20, 24'h000010);
      rdsr(8'h00, "R8 misaligned clears latch");
      rd1(24'h000000, 8'h33, "R8 misaligned no erase");

      // R8: erase without latch ignored
      erase(8'hD8, 24'h000000);
      rdsr(8'h00, "R8 no latch not busy");
      rd1(24'h000000, 8'h33, "R8 no latch no erase");

      // R8 / R9: aligned 4 KiB erase, busy gating
      cmd1(8'h06);
      erase(8'h20, 24'h000000);
      rdsr(8'h01, "R9 busy during erase");
      sel; xb(8'h9F, 8'hFF, "R1 opcode"); xb(8'h00, 8'hFF, "R9 id ignored while busy");
      xb(8'h00, 8'hFF, "R9 id ignored while busy"); desel;
      cmd1(8'h06);
      wait_clk(SWEEP_WAIT);
      rdsr(8'h00, "R9 latch set ignored while busy");
      rd1(24'h000000, 8'hFF, "R8 erased at 0");
      rd1(24'h0000FE, 8'hFF, "R8 erased at FE");

      // R8: whole-array erase
      cmd1(8'h06);
      prog1(24'h000800, 8'h5A);
      wait_clk(SETTLE);
      rd1(24'h000800, 8'h5A, "R7 program page 8");
      cmd1(8'h06);
      erase(8'hC7, 24'h000000);
      wait_clk(SWEEP_WAIT);
      rd1(24'h000800, 8'hFF, "R8 chip erase");

      // R10: unknown opcode and aborted transaction
      sel; xb(8'hAB, 8'hFF, "R1 opcode"); xb(8'h12, 8'hFF, "R10 unknown ignored");
      xb(8'h34, 8'hFF, "R10 unknown ignored"); desel;
      rdsr(8'h00, "R10 unknown no effect");
      sel; xb(8'h03, 8'hFF, "R1 opcode"); xb(8'h00, 8'hFF, "R1 addr"); desel;
      sel; xb(8'h9F, 8'hFF, "R1 opcode"); xb(8'h00, 8'hEF, "R10 restart after abort"); desel;

      wait_clk(20);
      if (exp_q.size() != 0) check(1'b0, "scoreboard-leftover", 8'(exp_q.size()), 8'h00);
      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog: got hung expected done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule